// File: doc/BRIEF.md
# Packed-Byte SIMD Execution Unit

This unit sits next to a 32-bit integer pipeline. It treats each 32-bit register operand as four packed 8-bit lanes and needs no vector register file. Lane 0 occupies bits 7:0 and lane 3 occupies bits 31:24. Each operation passes through two registered stages in a fixed order:

- The element-wise stage combines operand A with a prepared operand B, lane by lane.
- The reduction stage folds the enabled lanes into one scalar.

Either stage can be bypassed. A saturation flag and a signedness flag travel with every operation.

Operand B is prepared before the element-wise stage. It is either the register value or a replicated power-of-two immediate, and it is then reordered byte-wise by a swizzle selector. A SIMD control word sets the swizzle pattern and a per-lane enable mask. The 32-bit result is returned for write-back two cycles after the operation is issued.

Top module: `swar_simd_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `result` are cleared to 0.
- R2: An operation presented with `in_valid` high produces `out_valid` high exactly two clock edges later. `result` only changes when `out_valid` is set.
- R3: When `saturate`=0, `lane_op` ADD (1) and SUB (2) wrap modulo 256 in each lane.
- R4: When `saturate`=1, ADD and SUB clamp each lane to the lane range: [-128,127] if `is_signed`=1, [0,255] otherwise.
- R5: `lane_op` AND (3), OR (4) and XOR (5) work bitwise per lane.
- R6: `lane_op` MIN (6) and MAX (7) compare lanes as two's-complement bytes when `is_signed`=1 and as unsigned bytes otherwise.
- R7: When `use_imm`=1, operand B is replaced by the value 2^`imm_exp` in every lane, and `src_b` is ignored.
- R8: Swizzle: lane i of operand B takes source byte `simd_ctrl[2i+1:2i]`. The identity pattern is 0xE4 in `simd_ctrl[7:0]`.
- R9: Mask: `simd_ctrl[8+i]`=0 disables lane i. A disabled lane passes operand A's byte unchanged and is excluded from every reduction. A reduction with no lane enabled yields 0.
- R10: `red_op` SUM (1) adds the enabled lanes. When `saturate`=0 the sum is sign-extended to 32 bits if `is_signed`=1 and zero-extended otherwise.
- R11: With `saturate`=1, the SUM reduction is clamped to the lane range and then extended to 32 bits.
- R12: `red_op` MIN (2) and MAX (3) return the smallest or largest enabled lane, sign- or zero-extended to 32 bits per `is_signed`.
- R13: Bypass: `lane_op` PASS (0) forwards operand A to the reduction stage. `red_op` NONE (0) returns the four-lane vector from the element-wise stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| src_a | input | 32 | Operand A (four lanes) |
| src_b | input | 32 | Operand B (four lanes) |
| lane_op | input | 3 | Element-wise opcode (0 PASS … 7 MAX) |
| red_op | input | 2 | Reduction opcode (0 NONE, 1 SUM, 2 MIN, 3 MAX) |
| is_signed | input | 1 | Signed lane interpretation |
| saturate | input | 1 | Clamp instead of wrap |
| use_imm | input | 1 | Replace operand B by the immediate |
| imm_exp | input | 3 | Exponent of the power-of-two immediate |
| simd_ctrl | input | 12 | [7:0] swizzle, [11:8] lane enables |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Write-back value |

## Verification
Several properties are checked on every cycle:

- The two-edge valid pipeline.
- Masked-lane pass-through and the PASS and NONE bypasses across each stage register.
- The ordering bounds of unsigned saturating add and unsigned minimum.
- The rule that an unsigned maximum reduction is never below any enabled lane.

Exact arithmetic values can only be shown by the bench's directed scenarios. These include wrap versus clamp at the lane limits, signed versus unsigned comparisons, immediate replication, swizzle reordering, and extension of reductions.

// File: rtl/swar_pkg.sv
// Package: shared lane geometry and opcode encodings for the packed-byte unit.
// Assumes a 32-bit datapath built from equal-width lanes.
package swar_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 4;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int SEL_W   = $clog2(LANES);
    localparam int CTRL_W  = LANES * SEL_W + LANES;
    localparam int IMM_W   = $clog2(LANE_W);

    typedef enum logic [2:0] {
        L_PASS = 3'd0, L_ADD = 3'd1, L_SUB = 3'd2, L_AND = 3'd3,
        L_OR   = 3'd4, L_XOR = 3'd5, L_MIN = 3'd6, L_MAX = 3'd7
    } lane_op_e;

    typedef enum logic [1:0] {
        R_NONE = 2'd0, R_SUM = 2'd1, R_MIN = 2'd2, R_MAX = 2'd3
    } red_op_e;
endpackage

// File: rtl/swar_operand.sv
// Module: prepares operand B. It selects the register or a replicated
// power-of-two immediate, then reorders the bytes by the swizzle selectors.
// Assumes the immediate exponent is below the lane width.
module swar_operand
    import swar_pkg::*;
(
    input  logic [DATA_W-1:0]       src_b,
    input  logic                    use_imm,
    input  logic [IMM_W-1:0]        imm_exp,
    input  logic [LANES*SEL_W-1:0]  swz,
    output logic [DATA_W-1:0]       b_out
);
    logic [DATA_W-1:0] base;

    // Choose between the register operand and the replicated immediate.
    always_comb begin
        base = src_b;
        if (use_imm)
            base = {LANES{LANE_W'(1) << imm_exp}};
    end

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_swz
            logic [SEL_W-1:0] sel;
            assign sel = swz[gi*SEL_W +: SEL_W];
            // Route the selected source byte into this lane.
            assign b_out[gi*LANE_W +: LANE_W] = base[sel*LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/swar_lane_alu.sv
// Module: one lane of the element-wise stage. It does wrap or clamp
// arithmetic, bitwise logic and signed or unsigned min/max.
// Assumes that a disabled lane must return operand A untouched.
module swar_lane_alu
    import swar_pkg::*;
(
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  lane_op_e          op,
    input  logic              sgn,
    input  logic              sat,
    input  logic              en,
    output logic [LANE_W-1:0] y
);
    localparam int EW = LANE_W + 2;

    logic signed [EW-1:0] ax, bx, sum, dif, lo, hi;
    logic                 a_lt_b;

    // Extend both bytes and derive the clamp limits for the active signedness.
    always_comb begin
        ax  = $signed({{2{sgn & a[LANE_W-1]}}, a});
        bx  = $signed({{2{sgn & b[LANE_W-1]}}, b});
        sum = ax + bx;
        dif = ax - bx;
        lo  = sgn ? -$signed(EW'(1) << (LANE_W-1)) : '0;
        hi  = sgn ? $signed((EW'(1) << (LANE_W-1)) - EW'(1))
                  : $signed((EW'(1) << LANE_W) - EW'(1));
        a_lt_b = sgn ? ($signed(a) < $signed(b)) : (a < b);
    end

    function automatic logic [LANE_W-1:0] clampv(logic signed [EW-1:0] v,
                                                 logic signed [EW-1:0] l,
                                                 logic signed [EW-1:0] h,
                                                 logic do_sat);
        if (do_sat && v > h)      return h[LANE_W-1:0];
        else if (do_sat && v < l) return l[LANE_W-1:0];
        else                      return v[LANE_W-1:0];
    endfunction

    // Select the lane result, or pass A when the lane is disabled.
    always_comb begin
        unique case (op)
            L_ADD:   y = clampv(sum, lo, hi, sat);
            L_SUB:   y = clampv(dif, lo, hi, sat);
            L_AND:   y = a & b;
            L_OR:    y = a | b;
            L_XOR:   y = a ^ b;
            L_MIN:   y = a_lt_b ? a : b;
            L_MAX:   y = a_lt_b ? b : a;
            default: y = a;
        endcase
        if (!en)
            y = a;
    end
endmodule

// File: rtl/swar_reduce.sv
// Module: the cross-lane reduction stage. It computes sum, min or max over the
// enabled lanes, or returns the vector unchanged when the stage is bypassed.
// Assumes that no enabled lane gives a zero scalar.
module swar_reduce
    import swar_pkg::*;
(
    input  logic [DATA_W-1:0] lanes,
    input  logic [LANES-1:0]  en,
    input  red_op_e           op,
    input  logic              sgn,
    input  logic              sat,
    output logic [DATA_W-1:0] y
);
    localparam int SUMW = LANE_W + SEL_W + 1;

    logic signed [SUMW-1:0] acc, best, lo, hi, v, clamped;
    logic                   found;

    // Fold the enabled lanes into a sum and a running min or max.
    always_comb begin
        acc   = '0;
        best  = '0;
        found = 1'b0;
        v     = '0;
        lo    = sgn ? -$signed(SUMW'(1) << (LANE_W-1)) : '0;
        hi    = sgn ? $signed((SUMW'(1) << (LANE_W-1)) - SUMW'(1))
                    : $signed((SUMW'(1) << LANE_W) - SUMW'(1));
        for (int i = 0; i < LANES; i++) begin
            v = $signed({{(SUMW-LANE_W){sgn & lanes[i*LANE_W+LANE_W-1]}},
                         lanes[i*LANE_W +: LANE_W]});
            if (en[i]) begin
                acc = acc + v;
                if (!found || (op == R_MIN && v < best) || (op == R_MAX && v > best))
                    best = v;
                found = 1'b1;
            end
        end
        clamped = acc;
        if (sat && acc > hi) clamped = hi;
        if (sat && acc < lo) clamped = lo;
    end

    // Select the reduction output, with sign- or zero-extension to full width.
    always_comb begin
        unique case (op)
            R_SUM:   y = DATA_W'(clamped);
            R_MIN,
            R_MAX:   y = DATA_W'(best);
            default: y = lanes;
        endcase
        if (op == R_SUM && (clamped[SUMW-1] & sgn))
            y = {{(DATA_W-SUMW){1'b1}}, clamped};
        if (op != R_NONE && op != R_SUM && (best[SUMW-1] & sgn))
            y = {{(DATA_W-SUMW){1'b1}}, best};
    end
endmodule

// File: rtl/swar_simd_unit.sv
// Module: top of the packed-byte SIMD unit. It holds operand preparation, the
// element-wise stage register and the reduction stage register.
// Assumes decode has already split the instruction into the opcode fields.
module swar_simd_unit
    import swar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       src_a,
    input  logic [31:0]       src_b,
    input  logic [2:0]        lane_op,
    input  logic [1:0]        red_op,
    input  logic              is_signed,
    input  logic              saturate,
    input  logic              use_imm,
    input  logic [2:0]        imm_exp,
    input  logic [11:0]       simd_ctrl,
    output logic              out_valid,
    output logic [31:0]       result
);
    localparam int SWZ_W = LANES * SEL_W;

    logic [DATA_W-1:0] b_prep, lane_vec, red_vec;
    logic [LANES-1:0]  mask;
    lane_op_e          lop;

    logic              s1_valid, s1_sgn, s1_sat;
    logic [DATA_W-1:0] s1_lanes;
    logic [LANES-1:0]  s1_mask;
    red_op_e           s1_red;

    assign mask = simd_ctrl[SWZ_W +: LANES];
    assign lop  = lane_op_e'(lane_op);

    swar_operand u_operand (
        .src_b   (src_b),
        .use_imm (use_imm),
        .imm_exp (imm_exp),
        .swz     (simd_ctrl[SWZ_W-1:0]),
        .b_out   (b_prep)
    );

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            swar_lane_alu u_alu (
                .a   (src_a[gl*LANE_W +: LANE_W]),
                .b   (b_prep[gl*LANE_W +: LANE_W]),
                .op  (lop),
                .sgn (is_signed),
                .sat (saturate),
                .en  (mask[gl]),
                .y   (lane_vec[gl*LANE_W +: LANE_W])
            );
        end
    endgenerate

    // Element-wise stage register: capture the lane vector and reduction controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_lanes <= '0;
            s1_mask  <= '0;
            s1_red   <= R_NONE;
            s1_sgn   <= 1'b0;
            s1_sat   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_lanes <= lane_vec;
                s1_mask  <= mask;
                s1_red   <= red_op_e'(red_op);
                s1_sgn   <= is_signed;
                s1_sat   <= saturate;
            end
        end
    end

    swar_reduce u_reduce (
        .lanes (s1_lanes),
        .en    (s1_mask),
        .op    (s1_red),
        .sgn   (s1_sgn),
        .sat   (s1_sat),
        .y     (red_vec)
    );

    // Reduction stage register: publish the write-back value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                result <= red_vec;
        end
    end

    // R2
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> (!out_valid && $stable(result)));
    // R13
    lane_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_op == 3'd0) |=> (s1_lanes == $past(src_a)));
    // R13
    red_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_red == R_NONE) |=> (result == $past(s1_lanes)));

    generate
        for (gl = 0; gl < LANES; gl++) begin : g_chk
            // R9
            mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mask[gl]) |=>
                (s1_lanes[gl*LANE_W +: LANE_W] == $past(src_a[gl*LANE_W +: LANE_W])));
            // R4
            usat_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && lane_op == 3'd1 && saturate && !is_signed) |=>
                (s1_lanes[gl*LANE_W +: LANE_W] >= $past(src_a[gl*LANE_W +: LANE_W])));
            // R6
            umin_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && lane_op == 3'd6 && !is_signed) |=>
                (s1_lanes[gl*LANE_W +: LANE_W] <= $past(src_a[gl*LANE_W +: LANE_W])));
            // R12
            umax_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (s1_valid && s1_red == R_MAX && !s1_sgn && s1_mask[gl]) |=>
                (result >= DATA_W'($past(s1_lanes[gl*LANE_W +: LANE_W]))));
        end
    endgenerate
endmodule

// File: tb/test_swar_simd_unit.sv
module test_swar_simd_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] src_a, src_b;
    logic [2:0]  lane_op;
    logic [1:0]  red_op;
    logic        is_signed, saturate, use_imm;
    logic [2:0]  imm_exp;
    logic [11:0] simd_ctrl;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [11:0] ID_ALL = 12'hFE4;

    always #5 clk = ~clk;

    swar_simd_unit i_swar_simd_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .lane_op(lane_op), .red_op(red_op), .is_signed(is_signed), .saturate(saturate),
        .use_imm(use_imm), .imm_exp(imm_exp), .simd_ctrl(simd_ctrl),
        .out_valid(out_valid), .result(result)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent reference model built from the requirement text.
    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, int lop, int rop,
                                          bit sg, bit st, bit ui, int ik, logic [11:0] c);
        logic [31:0] base, lv;
        int lo, hi, av, bv, r, acc, best;
        bit found;
        lo = sg ? -128 : 0;
        hi = sg ? 127 : 255;
        base = ui ? {4{8'(1 << ik)}} : b;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] ab, bb;
            ab = a[8*i +: 8];
            bb = base[8*c[2*i +: 2] +: 8];
            av = sg ? int'($signed(ab)) : int'(ab);
            bv = sg ? int'($signed(bb)) : int'(bb);
            case (lop)
                1: r = av + bv;
                2: r = av - bv;
                3: r = int'(ab & bb);
                4: r = int'(ab | bb);
                5: r = int'(ab ^ bb);
                6: r = (av < bv) ? av : bv;
                7: r = (av > bv) ? av : bv;
                default: r = av;
            endcase
            if (st && (lop == 1 || lop == 2)) begin
                if (r > hi) r = hi;
                if (r < lo) r = lo;
            end
            if (!c[8+i]) r = int'(ab);
            lv[8*i +: 8] = 8'(r);
        end
        if (rop == 0) return lv;
        acc = 0; best = 0; found = 0;
        for (int i = 0; i < 4; i++) begin
            if (c[8+i]) begin
                av = sg ? int'($signed(lv[8*i +: 8])) : int'(lv[8*i +: 8]);
                acc += av;
                if (!found || (rop == 2 && av < best) || (rop == 3 && av > best)) best = av;
                found = 1;
            end
        end
        if (rop == 1) begin
            if (st && acc > hi) acc = hi;
            if (st && acc < lo) acc = lo;
            return 32'(acc);
        end
        return 32'(best);
    endfunction

    // Issue one operation, wait two edges and return the result.
    task automatic run(input logic [31:0] a, b, input int lop, rop, input bit sg, st, ui,
                       input int ik, input logic [11:0] c, output logic [31:0] res);
        @(negedge clk);
        src_a = a; src_b = b; lane_op = 3'(lop); red_op = 2'(rop);
        is_signed = sg; saturate = st; use_imm = ui; imm_exp = 3'(ik); simd_ctrl = c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        src_b = ~src_b;
        @(negedge clk);
        res = result;
    endtask

    task automatic op_check(string req, logic [31:0] a, b, int lop, rop, bit sg, st, ui,
                            int ik, logic [11:0] c);
        logic [31:0] r;
        run(a, b, lop, rop, sg, st, ui, ik, c, r);
        chk(req, r, model(a, b, lop, rop, sg, st, ui, ik, c));
    endtask

    task automatic t_reset();
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 result", result, 32'd0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        src_a = 32'h01020304; src_b = 32'h01010101; lane_op = 3'd1; red_op = 2'd0;
        is_signed = 0; saturate = 0; use_imm = 0; imm_exp = 0; simd_ctrl = ID_ALL;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 not yet valid", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R2 valid at two edges", 32'(out_valid), 32'd1);
        chk("R2 value", result, 32'h02030405);
        @(negedge clk);
        chk("R2 valid drops", 32'(out_valid), 32'd0);
        chk("R2 result held", result, 32'h02030405);
    endtask

    task automatic t_arith();
        logic [31:0] r;
        run(32'h7FFF8010, 32'h010180F0, 1, 0, 1, 0, 0, 0, ID_ALL, r);
        chk("R3 add wrap", r, 32'h80000000);
        run(32'h00108000, 32'h01200101, 2, 0, 0, 0, 0, 0, ID_ALL, r);
        chk("R3 sub wrap", r, 32'hFFF07FFF);
        run(32'h7FFF8010, 32'h010180F0, 1, 0, 1, 1, 0, 0, ID_ALL, r);
        chk("R4 signed sat add", r, 32'h7F008000);
        run(32'h7FFF8010, 32'h010180F0, 1, 0, 0, 1, 0, 0, ID_ALL, r);
        chk("R4 unsigned sat add", r, 32'h80FFFFFF);
        run(32'h00108000, 32'h01200101, 2, 0, 0, 1, 0, 0, ID_ALL, r);
        chk("R4 unsigned sat sub", r, 32'h00007F00);
        run(32'h80107F00, 32'h01200101, 2, 0, 1, 1, 0, 0, ID_ALL, r);
        chk("R4 signed sat sub", r, 32'h80F07EFF);
    endtask

    task automatic t_logic_minmax();
        op_check("R5 and", 32'hF0F0AA55, 32'hFF0F0FF0, 3, 0, 0, 0, 0, 0, ID_ALL);
        op_check("R5 or",  32'hF0F0AA55, 32'hFF0F0FF0, 4, 0, 0, 0, 0, 0, ID_ALL);
        op_check("R5 xor", 32'hF0F0AA55, 32'hFF0F0FF0, 5, 0, 0, 0, 0, 0, ID_ALL);
        op_check("R6 smin", 32'h807F00FF, 32'h7F800101, 6, 0, 1, 0, 0, 0, ID_ALL);
        op_check("R6 umax", 32'h807F00FF, 32'h7F800101, 7, 0, 0, 0, 0, 0, ID_ALL);
        begin
            logic [31:0] r;
            run(32'h807F00FF, 32'h7F800101, 6, 0, 1, 0, 0, 0, ID_ALL, r);
            chk("R6 signed min value", r, 32'h808000FF);
            run(32'h807F00FF, 32'h7F800101, 6, 0, 0, 0, 0, 0, ID_ALL, r);
            chk("R6 unsigned min value", r, 32'h7F7F0001);
        end
    endtask

    task automatic t_imm_swizzle();
        logic [31:0] r;
        run(32'h01020304, 32'hDEADBEEF, 1, 0, 0, 0, 1, 3, ID_ALL, r);
        chk("R7 imm 8", r, 32'h090A0B0C);
        op_check("R7 imm 128", 32'h00FF7F01, 32'h12345678, 1, 0, 0, 1, 1, 7, ID_ALL);
        run(32'h0, 32'h44332211, 4, 0, 0, 0, 0, 0, 12'hF1B, r);
        chk("R8 reverse", r, 32'h11223344);
        run(32'h0, 32'h44332211, 4, 0, 0, 0, 0, 0, 12'hFAA, r);
        chk("R8 broadcast lane2", r, 32'h33333333);
    endtask

    task automatic t_mask();
        logic [31:0] r;
        run(32'hAABBCCDD, 32'hFFFFFFFF, 5, 0, 0, 0, 0, 0, 12'h5E4, r);
        chk("R9 masked lanes pass A", r, 32'hAA44CC22);
        run(32'h01020304, 32'h0, 0, 1, 0, 0, 0, 0, 12'h5E4, r);
        chk("R9 masked excluded from sum", r, 32'h00000006);
        run(32'h01020304, 32'h0, 0, 1, 0, 0, 0, 0, 12'h0E4, r);
        chk("R9 empty mask sum", r, 32'h0);
        run(32'h81020304, 32'h0, 0, 3, 1, 0, 0, 0, 12'h0E4, r);
        chk("R9 empty mask max", r, 32'h0);
    endtask

    task automatic t_reduce();
        logic [31:0] r;
        run(32'hFFFFFFFF, 32'h0, 0, 1, 1, 0, 0, 0, ID_ALL, r);
        chk("R10 signed sum", r, 32'hFFFFFFFC);
        run(32'hFFFFFFFF, 32'h0, 0, 1, 0, 0, 0, 0, ID_ALL, r);
        chk("R10 unsigned sum", r, 32'h000003FC);
        run(32'h7F7F7F7F, 32'h0, 0, 1, 1, 1, 0, 0, ID_ALL, r);
        chk("R11 signed sat sum high", r, 32'h0000007F);
        run(32'h80808080, 32'h0, 0, 1, 1, 1, 0, 0, ID_ALL, r);
        chk("R11 signed sat sum low", r, 32'hFFFFFF80);
        run(32'hFFFFFFFF, 32'h0, 0, 1, 0, 1, 0, 0, ID_ALL, r);
        chk("R11 unsigned sat sum", r, 32'h000000FF);
        run(32'h80017FFE, 32'h0, 0, 2, 1, 0, 0, 0, ID_ALL, r);
        chk("R12 signed min", r, 32'hFFFFFF80);
        run(32'h80017FFE, 32'h0, 0, 3, 1, 0, 0, 0, ID_ALL, r);
        chk("R12 signed max", r, 32'h0000007F);
        run(32'h80017FFE, 32'h0, 0, 2, 0, 0, 0, 0, ID_ALL, r);
        chk("R12 unsigned min", r, 32'h00000001);
        run(32'h80017FFE, 32'h0, 0, 3, 0, 0, 0, 0, ID_ALL, r);
        chk("R12 unsigned max", r, 32'h000000FE);
        op_check("R12 chained add then max", 32'h10203040, 32'h05050505, 1, 3, 0, 0, 0, 0, ID_ALL);
    endtask

    task automatic t_bypass();
        logic [31:0] r;
        run(32'hCAFEF00D, 32'h12345678, 0, 0, 0, 1, 0, 0, ID_ALL, r);
        chk("R13 both stages bypassed", r, 32'hCAFEF00D);
        op_check("R13 reduction bypassed", 32'h11223344, 32'h01010101, 2, 0, 1, 0, 0, 0, ID_ALL);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; src_a = '1; src_b = '1; lane_op = 3'd1; red_op = 2'd0;
        is_signed = 0; saturate = 0; use_imm = 0; imm_exp = 0; simd_ctrl = ID_ALL;
        repeat (3) @(negedge clk);
        t_reset();
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        t_latency();
        t_arith();
        t_logic_minmax();
        t_imm_swizzle();
        t_mask();
        t_reduce();
        t_bypass();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule